// File: doc/BRIEF.md
# Sub-page write-permission table walker

This block decides whether a guest write to a 4 KB page may go ahead, at a granularity of 128-byte regions. Each request carries the guest physical address, the access direction and two bits taken from the second-stage leaf entry already found for that page: its write permission and its sub-page protect bit. A global enable pin and a root page register complete the inputs. When sub-page checking applies, the block walks a four-level protection table in memory, one 64-bit entry per read, through a single-outstanding read port. It then reports one of four outcomes.

The outcome codes are allow (0), permission violation (1), table miss (2) and table misconfiguration (3). They come with an exit-qualification word and the faulting guest address. Requests use valid/ready. `req_ready` is high only when no walk is in flight, so a pending request simply waits. The memory read request also uses valid/ready: once `mem_rd_valid` is raised, it and `mem_rd_addr` hold until `mem_rd_ready` is seen high at a clock edge. There is at most one read outstanding. The block takes `mem_rsp_valid` only while it is waiting for the answer to a read it has issued. The result pins change only in the cycle of the one-cycle `res_done` pulse and hold until the next one.

Top module: `spp_walker`

## Requirements
- R1: When `spp_en` is 0 or `req_leaf_spp` is 0, a write completes with no memory read: outcome 0 if `req_leaf_wr` is 1, else outcome 1.
- R2: A write with sub-page checking active and `req_leaf_wr` = 1 completes as outcome 0 with no memory read.
- R3: A read request (`req_write` = 0) completes as outcome 0 with no memory read, whatever the other inputs.
- R4: A walk reads at most four entries, in order. The L4 entry address is {`root_page`, GPA[47:39], 3'b000}. The L3, L2 and L1 entries come from the previous entry's bits PA_W-1:12 with GPA[38:30], GPA[29:21] and GPA[20:12].
- R5: An L4, L3 or L2 entry with any of bits 11:1 or 63:PA_W set gives outcome 3 and ends the walk, even when bit 0 is clear.
- R6: An L4, L3 or L2 entry with bit 0 clear and no reserved bit set gives outcome 2 and ends the walk.
- R7: An L1 entry with any odd bit set gives outcome 3.
- R8: Otherwise, L1 bit 2×GPA[11:7] selects the outcome: 1 gives outcome 0 and 0 gives outcome 1.
- R9: `res_qual` has bit 11 set for outcome 2 and is all zero otherwise. `res_gpa` is the address of the completed request.
- R10: `res_done` pulses for one cycle per request: one cycle after acceptance for a request with no walk, and one cycle after the final response for a walk. `res_kind` and `res_gpa` change only in that cycle. After reset, `res_done` is 0 and `req_ready` is 1.
- R11: While `mem_rd_valid` is high and `mem_rd_ready` is low, `mem_rd_valid` stays high and `mem_rd_addr` stays stable.
- R12: `req_ready` is low from the acceptance of a request that walks until its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spp_en | input | 1 | Global sub-page checking enable |
| root_page | input | PA_W-12 | Page number of the L4 table |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_write | input | 1 | 1 for a write access |
| req_gpa | input | GPA_W | Guest physical address |
| req_leaf_wr | input | 1 | Leaf entry write permission |
| req_leaf_spp | input | 1 | Leaf entry sub-page protect bit |
| mem_rd_valid | output | 1 | Entry read request valid |
| mem_rd_ready | input | 1 | Entry read request taken |
| mem_rd_addr | output | PA_W | Byte address of the 64-bit entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry read data |
| res_done | output | 1 | One-cycle completion pulse |
| res_kind | output | 2 | Outcome: 0 allow, 1 violation, 2 miss, 3 misconfiguration |
| res_qual | output | 64 | Exit-qualification word |
| res_gpa | output | GPA_W | Address of the completed request |

## Verification
A wrong walk state shows up at the memory port within one read. The next `mem_rd_addr` would carry the wrong index slice or base, or an extra read would follow a terminating entry. The bench catches this because it counts reads and serves only the table it built. A wrong decision in the entry classifier appears at the same `res_done` pulse as a wrong `res_kind` or a wrong qualification bit. A stuck or skipped state shows as a missing pulse, a bypass that takes longer than one cycle, or `req_ready` raised mid-walk. Random stalls on both read handshakes expose any address that moves while the read is not yet taken.

// File: rtl/spp_pkg.sv
package spp_pkg;
  typedef enum logic [1:0] {
    OUT_ALLOW   = 2'd0,
    OUT_VIOL    = 2'd1,
    OUT_MISS    = 2'd2,
    OUT_MISCONF = 2'd3
  } spp_out_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD_L4 = 3'd1,
    ST_RD_L3 = 3'd2,
    ST_RD_L2 = 3'd3,
    ST_RD_L1 = 3'd4,
    ST_DONE  = 3'd5
  } spp_st_e;

  localparam int LEVELS      = 4;
  localparam int IDX_W       = 9;
  localparam int PAGE_SHIFT  = 12;
  localparam int ENTRY_SHIFT = 3;
  localparam int SUB_LSB     = 7;
  localparam int SUB_W       = PAGE_SHIFT - SUB_LSB;
  localparam int SUBPAGES    = 1 << SUB_W;
  localparam int QUAL_MISS   = 11;
  localparam int GPA_MIN_W   = PAGE_SHIFT + IDX_W * LEVELS;
endpackage

// File: rtl/spp_gate.sv
module spp_gate
  import spp_pkg::*;
(
  input  logic     en,
  input  logic     write,
  input  logic     leaf_wr,
  input  logic     leaf_spp,
  output logic     need_walk,
  output spp_out_e direct_kind
);
  always_comb begin
    need_walk   = write && en && leaf_spp && !leaf_wr;
    direct_kind = OUT_ALLOW;
    if (write && !leaf_wr) direct_kind = OUT_VIOL;
  end
endmodule

// File: rtl/spp_entry_check.sv
module spp_entry_check
  import spp_pkg::*;
#(
  parameter int PA_W = 40
) (
  input  logic                   is_leaf,
  input  logic [63:0]            entry,
  input  logic [SUB_W-1:0]       sub_idx,
  output logic                   misconf,
  output logic                   absent,
  output logic                   perm,
  output logic [PA_W-PAGE_SHIFT-1:0] next_base
);
  logic [SUBPAGES-1:0] perms;
  logic [SUBPAGES-1:0] odds;

  for (genvar i = 0; i < SUBPAGES; i++) begin : g_sub
    assign perms[i] = entry[2*i];
    assign odds[i]  = entry[2*i+1];
  end

  logic low_rsv, high_rsv;
  assign low_rsv   = |entry[PAGE_SHIFT-1:1];
  assign high_rsv  = |entry[63:PA_W];
  assign next_base = entry[PA_W-1:PAGE_SHIFT];
  assign perm      = perms[sub_idx];

  always_comb begin
    if (is_leaf) begin
      misconf = |odds;
      absent  = 1'b0;
    end else begin
      misconf = low_rsv || high_rsv;
      absent  = !entry[0];
    end
  end
endmodule

// File: rtl/spp_qual_build.sv
module spp_qual_build
  import spp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  spp_out_e    kind,
  output logic [63:0] qual
);
  always_comb begin
    qual = '0;
    qual[QUAL_MISS] = (kind == OUT_MISS);
  end

  p_qual_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (qual & ~(64'd1 << QUAL_MISS)) == 64'd0);
endmodule

// File: rtl/spp_walk_fsm.sv
module spp_walk_fsm
  import spp_pkg::*;
#(
  parameter int PA_W  = 40,
  parameter int GPA_W = 48
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [PA_W-PAGE_SHIFT-1:0] root_page,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [GPA_W-1:0]           req_gpa,
  input  logic                       need_walk,
  input  spp_out_e                   direct_kind,
  output logic                       mem_rd_valid,
  input  logic                       mem_rd_ready,
  output logic [PA_W-1:0]            mem_rd_addr,
  input  logic                       mem_rsp_valid,
  input  logic [63:0]                mem_rsp_data,
  output logic                       res_done,
  output spp_out_e                   res_kind,
  output logic [GPA_W-1:0]           res_gpa
);
  localparam int BASE_W = PA_W - PAGE_SHIFT;

  spp_st_e           state;
  logic              issued;
  logic [BASE_W-1:0] base_q;
  logic [GPA_W-1:0]  gpa_q;
  logic [2:0]        rd_cnt;

  logic       walking, accept, rd_fire, rsp_take;
  logic [1:0] lvl_m1;
  logic [IDX_W-1:0] idx;

  always_comb begin
    case (state)
      ST_RD_L4: lvl_m1 = 2'd3;
      ST_RD_L3: lvl_m1 = 2'd2;
      ST_RD_L2: lvl_m1 = 2'd1;
      default:  lvl_m1 = 2'd0;
    endcase
  end

  assign walking      = (state == ST_RD_L4) || (state == ST_RD_L3) ||
                        (state == ST_RD_L2) || (state == ST_RD_L1);
  assign req_ready    = (state == ST_IDLE) || (state == ST_DONE);
  assign accept       = req_valid && req_ready;
  assign mem_rd_valid = walking && !issued;
  assign rd_fire      = mem_rd_valid && mem_rd_ready;
  assign rsp_take     = walking && issued && mem_rsp_valid;
  assign idx          = gpa_q[PAGE_SHIFT + IDX_W*lvl_m1 +: IDX_W];
  assign mem_rd_addr  = {base_q, idx, {ENTRY_SHIFT{1'b0}}};

  logic misconf, absent, perm;
  logic [BASE_W-1:0] next_base;

  spp_entry_check #(.PA_W(PA_W)) u_check (
    .is_leaf   (state == ST_RD_L1),
    .entry     (mem_rsp_data),
    .sub_idx   (gpa_q[SUB_LSB +: SUB_W]),
    .misconf   (misconf),
    .absent    (absent),
    .perm      (perm),
    .next_base (next_base)
  );

  function automatic spp_st_e next_level(spp_st_e s);
    case (s)
      ST_RD_L4: return ST_RD_L3;
      ST_RD_L3: return ST_RD_L2;
      default:  return ST_RD_L1;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      issued   <= 1'b0;
      base_q   <= '0;
      gpa_q    <= '0;
      rd_cnt   <= '0;
      res_done <= 1'b0;
      res_kind <= OUT_ALLOW;
      res_gpa  <= '0;
    end else begin
      res_done <= 1'b0;
      if (accept) begin
        gpa_q  <= req_gpa;
        rd_cnt <= '0;
        issued <= 1'b0;
        if (need_walk) begin
          base_q <= root_page;
          state  <= ST_RD_L4;
        end else begin
          state    <= ST_DONE;
          res_done <= 1'b1;
          res_kind <= direct_kind;
          res_gpa  <= req_gpa;
        end
      end else if (rd_fire) begin
        issued <= 1'b1;
        rd_cnt <= rd_cnt + 3'd1;
      end else if (rsp_take) begin
        issued <= 1'b0;
        if (misconf || (state != ST_RD_L1 && absent) || state == ST_RD_L1) begin
          state    <= ST_DONE;
          res_done <= 1'b1;
          res_gpa  <= gpa_q;
          if (misconf)                 res_kind <= OUT_MISCONF;
          else if (state != ST_RD_L1)  res_kind <= OUT_MISS;
          else if (perm)               res_kind <= OUT_ALLOW;
          else                         res_kind <= OUT_VIOL;
        end else begin
          base_q <= next_base;
          state  <= next_level(state);
        end
      end
    end
  end

  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  p_rd_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !req_ready);

  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !res_done |-> ($stable(res_kind) && $stable(res_gpa)));

  p_depth_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt <= 3'd4);
endmodule

// File: rtl/spp_walker.sv
module spp_walker
  import spp_pkg::*;
#(
  parameter int PA_W  = 40,
  parameter int GPA_W = 48
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   spp_en,
  input  logic [PA_W-13:0]       root_page,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [GPA_W-1:0]       req_gpa,
  input  logic                   req_leaf_wr,
  input  logic                   req_leaf_spp,
  output logic                   mem_rd_valid,
  input  logic                   mem_rd_ready,
  output logic [PA_W-1:0]        mem_rd_addr,
  input  logic                   mem_rsp_valid,
  input  logic [63:0]            mem_rsp_data,
  output logic                   res_done,
  output logic [1:0]             res_kind,
  output logic [63:0]            res_qual,
  output logic [GPA_W-1:0]       res_gpa
);
  initial begin
    if (GPA_W < GPA_MIN_W || PA_W <= PAGE_SHIFT || PA_W >= 64)
      $error("spp_walker: unsupported address widths");
  end

  logic     need_walk;
  spp_out_e direct_kind;
  spp_out_e kind;

  spp_gate u_gate (
    .en          (spp_en),
    .write       (req_write),
    .leaf_wr     (req_leaf_wr),
    .leaf_spp    (req_leaf_spp),
    .need_walk   (need_walk),
    .direct_kind (direct_kind)
  );

  spp_walk_fsm #(.PA_W(PA_W), .GPA_W(GPA_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .root_page     (root_page),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_gpa       (req_gpa),
    .need_walk     (need_walk),
    .direct_kind   (direct_kind),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .res_done      (res_done),
    .res_kind      (kind),
    .res_gpa       (res_gpa)
  );

  spp_qual_build u_qual (
    .clk   (clk),
    .rst_n (rst_n),
    .kind  (kind),
    .qual  (res_qual)
  );

  assign res_kind = kind;
endmodule

// File: tb/spp_walker_bench.sv
module spp_walker_bench;
  localparam int PA_W  = 40;
  localparam int GPA_W = 48;
  localparam logic [1:0] K_ALLOW = 2'd0, K_VIOL = 2'd1, K_MISS = 2'd2, K_BAD = 2'd3;
  localparam logic [63:0] ODD_MASK = 64'hAAAA_AAAA_AAAA_AAAA;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, spp_en, req_valid, req_ready, req_write, req_leaf_wr, req_leaf_spp;
  logic [PA_W-13:0] root_page;
  logic [GPA_W-1:0] req_gpa, res_gpa;
  logic mem_rd_valid, mem_rd_ready, mem_rsp_valid, res_done;
  logic [PA_W-1:0] mem_rd_addr;
  logic [63:0] mem_rsp_data, res_qual;
  logic [1:0] res_kind;

  spp_walker #(.PA_W(PA_W), .GPA_W(GPA_W)) u_spp_walker (
    .clk(clk), .rst_n(rst_n), .spp_en(spp_en), .root_page(root_page),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_gpa(req_gpa), .req_leaf_wr(req_leaf_wr), .req_leaf_spp(req_leaf_spp),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_done(res_done), .res_kind(res_kind), .res_qual(res_qual), .res_gpa(res_gpa)
  );

  int checks = 0, errors = 0, rd_count = 0;
  logic [63:0] mem [logic [PA_W-1:0]];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] peek(input logic [PA_W-1:0] a);
    if (mem.exists(a)) return mem[a];
    return 64'd0;
  endfunction

  function automatic logic [PA_W-1:0] ent_addr(input logic [PA_W-13:0] base, input logic [GPA_W-1:0] g, input int lvl);
    logic [8:0] ix;
    ix = g[12 + 9*(lvl-1) +: 9];
    return {base, ix, 3'b000};
  endfunction

  // Reference walk computed from the requirements against the bench table
  function automatic logic [1:0] ref_walk(input logic [GPA_W-1:0] g, output int nrd);
    logic [PA_W-13:0] base;
    logic [63:0] e;
    base = root_page;
    nrd = 0;
    for (int lvl = 4; lvl >= 1; lvl--) begin
      e = peek(ent_addr(base, g, lvl));
      nrd++;
      if (lvl > 1) begin
        if (e[11:1] != 0 || e[63:PA_W] != 0) return K_BAD;   // R5
        if (!e[0]) return K_MISS;                           // R6
        base = e[PA_W-1:12];
      end else begin
        if ((e & ODD_MASK) != 0) return K_BAD;              // R7
        return e[2*g[11:7]] ? K_ALLOW : K_VIOL;             // R8
      end
    end
    return K_BAD;
  endfunction

  // fault: 0 none, 1 absent, 2 low reserved, 3 high reserved, 4 absent plus reserved
  task automatic build(input logic [GPA_W-1:0] g, input int flvl, input int fault, input logic [63:0] l1);
    logic [PA_W-13:0] base, nxt;
    logic [63:0] e;
    mem.delete();
    base = root_page;
    for (int lvl = 4; lvl >= 2; lvl--) begin
      nxt = base + 28'd1;
      e = {24'd0, nxt, 12'h001};
      if (lvl == flvl) begin
        case (fault)
          1: e[0] = 1'b0;
          2: e[1 + ($urandom % 11)] = 1'b1;
          3: e[PA_W + ($urandom % (64-PA_W))] = 1'b1;
          4: begin e[0] = 1'b0; e[5] = 1'b1; end
          default: ;
        endcase
      end
      mem[ent_addr(base, g, lvl)] = e;
      base = nxt;
    end
    mem[ent_addr(base, g, 1)] = l1;
  endtask

  // Memory responder with random back-pressure and latency
  initial begin
    mem_rd_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_rd_valid) begin
        logic [PA_W-1:0] a0;
        int d, lat;
        a0 = mem_rd_addr;
        d = $urandom % 3;
        chk(!req_ready, "R12 req_ready during walk", 64'(req_ready), 64'd0);
        for (int k = 0; k < d; k++) begin
          @(negedge clk);
          chk(mem_rd_valid && mem_rd_addr == a0, "R11 read held under stall", 64'(mem_rd_addr), 64'(a0));
        end
        mem_rd_ready = 1'b1;
        @(negedge clk);
        mem_rd_ready = 1'b0;
        rd_count++;
        lat = $urandom % 3;
        for (int k = 0; k < lat; k++) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data = peek(a0);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  logic [1:0] got_kind;
  logic [63:0] got_qual;
  logic [GPA_W-1:0] got_gpa;
  int got_rd, got_cyc;

  task automatic run_req(input bit en, input bit wr, input logic [GPA_W-1:0] g, input bit lwr, input bit lspp);
    int start;
    @(negedge clk);
    spp_en = en; req_write = wr; req_gpa = g; req_leaf_wr = lwr; req_leaf_spp = lspp;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    start = rd_count;
    @(negedge clk);
    req_valid = 1'b0;
    got_cyc = 1;
    while (!res_done && got_cyc < 400) begin
      @(negedge clk);
      got_cyc++;
    end
    chk(res_done, "R10 done pulse seen", 64'(res_done), 64'd1);
    got_kind = res_kind; got_qual = res_qual; got_gpa = res_gpa;
    got_rd = rd_count - start;
  endtask

  task automatic check_result(input string tag, input logic [1:0] ek, input int erd, input logic [GPA_W-1:0] g);
    chk(got_kind == ek, {tag, " kind"}, 64'(got_kind), 64'(ek));
    chk(got_rd == erd, {tag, " R4 read count"}, 64'(got_rd), 64'(erd));
    chk(got_qual == ((ek == K_MISS) ? 64'h800 : 64'h0), {tag, " R9 qual"}, got_qual, (ek == K_MISS) ? 64'h800 : 64'h0);
    chk(got_gpa == g, {tag, " R9 gpa"}, 64'(got_gpa), 64'(g));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [GPA_W-1:0] g;
    logic [63:0] l1;
    logic [1:0] ek;
    int erd;
    void'($urandom(32'h5EED1234));
    rst_n = 1'b0; spp_en = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_gpa = '0;
    req_leaf_wr = 1'b0; req_leaf_spp = 1'b0; root_page = 28'h0000010;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!res_done && req_ready && !mem_rd_valid, "R10 reset state", {res_done, req_ready, mem_rd_valid}, 64'b010);

    g = 48'h1234_5678_9ABC;
    build(g, 0, 0, 64'h5555_5555_5555_5555);
    run_req(1'b0, 1'b1, g, 1'b0, 1'b1);
    check_result("R1 disabled nonwritable", K_VIOL, 0, g);
    chk(got_cyc == 1, "R1 R10 bypass latency", 64'(got_cyc), 64'd1);
    run_req(1'b1, 1'b1, g, 1'b1, 1'b0);
    check_result("R1 no protect bit writable", K_ALLOW, 0, g);
    run_req(1'b1, 1'b1, g, 1'b0, 1'b0);
    check_result("R1 no protect bit nonwritable", K_VIOL, 0, g);
    run_req(1'b1, 1'b1, g, 1'b1, 1'b1);
    check_result("R2 writable leaf", K_ALLOW, 0, g);
    run_req(1'b1, 1'b0, g, 1'b0, 1'b1);
    check_result("R3 read access", K_ALLOW, 0, g);
    chk(got_cyc == 1, "R3 bypass latency", 64'(got_cyc), 64'd1);

    g = {36'h0AB_CDE1_23, 12'hF80};              // sub index 31
    build(g, 0, 0, 64'h4000_0000_0000_0000);
    run_req(1'b1, 1'b1, g, 1'b0, 1'b1);
    check_result("R8 last region allowed", K_ALLOW, 4, g);
    g = {36'h0AB_CDE1_23, 12'h07F};              // sub index 0
    build(g, 0, 0, 64'h5555_5555_5555_5554);
    run_req(1'b1, 1'b1, g, 1'b0, 1'b1);
    check_result("R8 first region denied", K_VIOL, 4, g);
    build(g, 4, 1, 64'h1);
    run_req(1'b1, 1'b1, g, 1'b0, 1'b1);
    check_result("R6 miss at L4", K_MISS, 1, g);
    build(g, 3, 4, 64'h1);
    run_req(1'b1, 1'b1, g, 1'b0, 1'b1);
    check_result("R5 misconf ahead of miss", K_BAD, 2, g);
    build(g, 2, 3, 64'h1);
    run_req(1'b1, 1'b1, g, 1'b0, 1'b1);
    check_result("R5 high reserved L2", K_BAD, 3, g);
    build(g, 0, 0, 64'h3);
    run_req(1'b1, 1'b1, g, 1'b0, 1'b1);
    check_result("R7 odd bit L1", K_BAD, 4, g);
    repeat (3) @(negedge clk);
    chk(!res_done && res_kind == K_BAD, "R10 result held", 64'(res_kind), 64'(K_BAD));

    for (int it = 0; it < 300; it++) begin
      int flvl, fault;
      logic en, wr, lwr, lspp;
      g = {$urandom, $urandom};
      flvl = 2 + ($urandom % 3);
      fault = ($urandom % 2) ? 0 : ($urandom % 5);
      l1 = {$urandom, $urandom} & ~ODD_MASK;
      if (($urandom % 8) == 0) l1[1 + 2*($urandom % 32)] = 1'b1;
      build(g, flvl, fault, l1);
      en = ($urandom % 8) != 0; wr = ($urandom % 8) != 0;
      lwr = ($urandom % 6) == 0; lspp = ($urandom % 8) != 0;
      if (!wr) begin ek = K_ALLOW; erd = 0; end
      else if (!(en && lspp)) begin ek = lwr ? K_ALLOW : K_VIOL; erd = 0; end
      else if (lwr) begin ek = K_ALLOW; erd = 0; end
      else ek = ref_walk(g, erd);
      run_req(en, wr, g, lwr, lspp);
      check_result("R4 random", ek, erd, g);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule